// File: doc/BRIEF.md
# Justified-Format Audio Serial Transmitter

This block turns parallel stereo samples into a one-bit serial stream for a digital audio link. It is a slave: an external bit clock and frame clock set the timing, and both are brought into the block's own system clock domain through a short synchronizer chain. The frame clock marks the two halves of each frame. The left word goes out while it is high and the right word while it is low. Data bits change after falling bit-clock edges, so a receiver can take them on the next rising edge.

Two alignments are offered, chosen by a format input. In left-aligned format the most significant bit comes first, in the first bit slot of each half-frame, and the line is held low once the word is done. In right-aligned format the word is pushed to the end of the half-frame: zero padding bits come first, and the least significant bit sits in the last slot before the frame clock toggles. The number of bit slots per half-frame is an input, and so is the active word length.

Words enter through a valid/ready handshake into a one-pair holding register. The pair moves into the shifter at the start of each left half-frame. If no new pair has been loaded, the previous pair is sent again.

Top module: `jsa_tx`

## Requirements
- R1: `sdout` changes only in the system clock cycle after a falling bit-clock edge has passed the synchronizer, so it is stable from every rising bit-clock edge up to the next falling edge.
- R2: In left-aligned format (`fmt_sel` = 0), slot k of a half-frame (slot 0 starts on the falling edge where the frame clock toggles) carries word bit `word_len-1-k`. The most significant bit is in slot 0.
- R3: In left-aligned format, every slot k with k >= `word_len` carries 0.
- R4: In right-aligned format (`fmt_sel` = 1), slot k carries word bit `half_len-1-k` when that index is below `word_len`, and 0 otherwise. The least significant bit is in the last slot and the leading slots are zero padding.
- R5: Slots while `lrclk` is 1 carry the left word and slots while `lrclk` is 0 carry the right word.
- R6: `in_ready` is 1 when the holding register is empty. A cycle with `in_valid` and `in_ready` both 1 stores `in_left`/`in_right` and drops `in_ready` on the next cycle. `in_valid` while `in_ready` is 0 has no effect on the stored pair.
- R7: A stored pair takes effect at the start of the next left half-frame, and `in_ready` returns to 1 then. Without a new pair, the previous words are sent again.
- R8: In left-aligned format with `word_len` > `half_len`, only the upper `half_len` bits of the word are sent, and the low-order bits are dropped.
- R9: In right-aligned format with `word_len` > `half_len`, only the lower `half_len` bits of the word are sent, and the high-order bits are dropped.
- R10: After reset, `sdout` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External frame clock, 1 = left half |
| fmt_sel | input | 1 | 0 = left-aligned, 1 = right-aligned |
| word_len | input | LEN_W (6) | Active word length in bits |
| half_len | input | HALF_W (7) | Bit slots per half-frame |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding register empty |
| in_left | input | SAMPLE_W (32) | Left word, right-aligned in the bus |
| in_right | input | SAMPLE_W (32) | Right word, right-aligned in the bus |
| sdout | output | 1 | Serial data line |

## Verification
With the default two synchronizer stages, a falling bit-clock edge that the bench drives at a falling system clock edge moves `sdout` two and a half system clock periods later. The bench then holds the bit clock low for six system clocks and samples `sdout` three clocks into the high phase. That is well after the update and well before the next fall. It samples `sdout` a second time just before that next fall to confirm the line held still. `in_ready` is registered, so it drops one system clock after an accepted transfer and rises one system clock after the internal left-start event. The bench reads it at the falling system clock edge after those events. Each half-frame's captured slots are compared with a slot vector that the bench builds from the format, the word length and the half-frame length.

// File: rtl/jsa_pkg.sv
package jsa_pkg;
    typedef enum logic {
        FMT_LEFT_JUST  = 1'b0,
        FMT_RIGHT_JUST = 1'b1
    } fmt_e;
endpackage

// File: rtl/jsa_sync.sv
module jsa_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else if (STAGES == 1) chain_q <= d_i;
                else chain_q <= {chain_q[STAGES-2:0], d_i};
            end
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/jsa_clk_track.sv
module jsa_clk_track #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrclk_i,
    output logic fall_o,
    output logic lr_now_o,
    output logic lr_edge_o,
    output logic left_start_o
);
    logic bclk_s, lr_s;
    logic bclk_prev_q, lr_prev_q;

    jsa_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_bclk (
        .clk(clk), .rst_n(rst_n), .d_i(bclk_i), .q_o(bclk_s)
    );
    jsa_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_lr (
        .clk(clk), .rst_n(rst_n), .d_i(lrclk_i), .q_o(lr_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_prev_q <= 1'b1;
            lr_prev_q   <= 1'b0;
        end else begin
            bclk_prev_q <= bclk_s;
            if (fall_o) lr_prev_q <= lr_s;
        end
    end

    assign fall_o       = bclk_prev_q & ~bclk_s;
    assign lr_now_o     = lr_s;
    assign lr_edge_o    = fall_o & (lr_s != lr_prev_q);
    assign left_start_o = lr_edge_o & lr_s;
endmodule

// File: rtl/jsa_bit_pick.sv
module jsa_bit_pick
    import jsa_pkg::*;
#(
    parameter int SAMPLE_W = 32,
    parameter int LEN_W    = 6,
    parameter int HALF_W   = 7
) (
    input  fmt_e                fmt_i,
    input  logic [SAMPLE_W-1:0] word_i,
    input  logic [LEN_W-1:0]    word_len_i,
    input  logic [HALF_W-1:0]   half_len_i,
    input  logic [HALF_W-1:0]   slot_i,
    output logic                bit_o
);
    localparam int IW    = ((HALF_W > LEN_W) ? HALF_W : LEN_W) + 2;
    localparam int IDX_W = $clog2(SAMPLE_W);

    logic [IW-1:0] slot_e, len_e, half_e, pos;

    always_comb begin
        slot_e = IW'(slot_i);
        half_e = IW'(half_len_i);
        len_e  = IW'(word_len_i);
        if (len_e > IW'(SAMPLE_W)) len_e = IW'(SAMPLE_W);
        pos   = '0;
        bit_o = 1'b0;
        if (fmt_i == FMT_LEFT_JUST) begin
            if (slot_e < len_e) begin
                pos   = len_e - IW'(1) - slot_e;
                bit_o = word_i[pos[IDX_W-1:0]];
            end
        end else begin
            if (slot_e < half_e) begin
                pos = half_e - IW'(1) - slot_e;
                if (pos < len_e) bit_o = word_i[pos[IDX_W-1:0]];
            end
        end
    end
endmodule

// File: rtl/jsa_tx.sv
module jsa_tx
    import jsa_pkg::*;
#(
    parameter int SAMPLE_W    = 32,
    parameter int HALF_MAX    = 64,
    parameter int SYNC_STAGES = 2,
    localparam int LEN_W      = $clog2(SAMPLE_W + 1),
    localparam int HALF_W     = $clog2(HALF_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                lrclk,
    input  logic                fmt_sel,
    input  logic [LEN_W-1:0]    word_len,
    input  logic [HALF_W-1:0]   half_len,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                sdout
);
    typedef struct packed {
        logic                sdout;
        logic                pending;
        logic [SAMPLE_W-1:0] hold_l;
        logic [SAMPLE_W-1:0] hold_r;
        logic [SAMPLE_W-1:0] cur_l;
        logic [SAMPLE_W-1:0] cur_r;
        logic [HALF_W-1:0]   slot;
    } tx_state_t;

    tx_state_t st_d, st_q;

    logic bclk_fall, lr_now, lr_edge, left_start;
    logic [HALF_W-1:0]   slot_nx;
    logic [SAMPLE_W-1:0] cur_l_nx, cur_r_nx, word_nx;
    logic                pick_bit;
    logic                swap_in;

    jsa_clk_track #(.SYNC_STAGES(SYNC_STAGES)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_i      (bclk),
        .lrclk_i     (lrclk),
        .fall_o      (bclk_fall),
        .lr_now_o    (lr_now),
        .lr_edge_o   (lr_edge),
        .left_start_o(left_start)
    );

    // Slot position and active words after this cycle
    always_comb begin
        swap_in  = left_start & st_q.pending;
        slot_nx  = st_q.slot;
        if (bclk_fall) begin
            if (lr_edge) slot_nx = '0;
            else if (st_q.slot != {HALF_W{1'b1}}) slot_nx = st_q.slot + HALF_W'(1);
        end
        cur_l_nx = swap_in ? st_q.hold_l : st_q.cur_l;
        cur_r_nx = swap_in ? st_q.hold_r : st_q.cur_r;
        word_nx  = lr_now ? cur_l_nx : cur_r_nx;
    end

    jsa_bit_pick #(.SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W), .HALF_W(HALF_W)) u_pick (
        .fmt_i     (fmt_e'(fmt_sel)),
        .word_i    (word_nx),
        .word_len_i(word_len),
        .half_len_i(half_len),
        .slot_i    (slot_nx),
        .bit_o     (pick_bit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.slot  = slot_nx;
        st_d.cur_l = cur_l_nx;
        st_d.cur_r = cur_r_nx;
        if (bclk_fall) st_d.sdout = pick_bit;
        if (swap_in) begin
            st_d.pending = 1'b0;
        end else if (in_valid && !st_q.pending) begin
            st_d.hold_l  = in_left;
            st_d.hold_r  = in_right;
            st_d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready = ~st_q.pending;
    assign sdout    = st_q.sdout;
endmodule

// File: rtl/jsa_tx_check.sv
module jsa_tx_check
    import jsa_pkg::*;
#(
    parameter int LEN_W  = 6,
    parameter int HALF_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fmt_sel,
    input logic [LEN_W-1:0]  word_len,
    input logic [HALF_W-1:0] half_len,
    input logic              in_valid,
    input logic              in_ready,
    input logic              sdout,
    input logic              fall,
    input logic              left_start,
    input logic [HALF_W-1:0] slot_q
);
    localparam int IW = ((HALF_W > LEN_W) ? HALF_W : LEN_W) + 2;

    logic [IW-1:0] pad_sum;
    logic          pad_zone, tail_zone;

    always_comb begin
        pad_sum   = IW'(slot_q) + IW'(word_len);
        pad_zone  = pad_sum < IW'(half_len);
        tail_zone = IW'(slot_q) >= IW'(word_len);
    end

    p_sdout_after_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdout) |-> $past(fall));

    p_lj_tail_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fall) && $past(fmt_sel) == FMT_LEFT_JUST && tail_zone) |-> !sdout);

    p_rj_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fall) && $past(fmt_sel) == FMT_RIGHT_JUST && pad_zone) |-> !sdout);

    p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_ready_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(left_start));
endmodule

bind jsa_tx jsa_tx_check #(.LEN_W(LEN_W), .HALF_W(HALF_W)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_sel   (fmt_sel),
    .word_len  (word_len),
    .half_len  (half_len),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .sdout     (sdout),
    .fall      (bclk_fall),
    .left_start(left_start),
    .slot_q    (st_q.slot)
);

// File: tb/jsa_tx_bench.sv
module jsa_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 32;
    localparam int LW = 6;
    localparam int HW = 7;
    localparam int BH = 6;

    typedef struct packed {
        logic          fmt;
        logic [LW-1:0] wl;
        logic [HW-1:0] hl;
        logic          load;
        logic [SW-1:0] l;
        logic [SW-1:0] r;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'd16, 7'd20, 1'b1, 32'h0000A5C3, 32'hFFFF1234},
        '{1'b0, 6'd24, 7'd32, 1'b1, 32'h00800001, 32'h007FFFFE},
        '{1'b1, 6'd16, 7'd20, 1'b1, 32'h0000A5C3, 32'h00001234},
        '{1'b1, 6'd20, 7'd32, 1'b1, 32'h000F0F0F, 32'h000F0F1E},
        '{1'b0, 6'd24, 7'd16, 1'b1, 32'h00C3A55A, 32'h003C5AA5},
        '{1'b1, 6'd24, 7'd16, 1'b1, 32'h00C3A55A, 32'h003C5AA5},
        '{1'b1, 6'd16, 7'd24, 1'b0, 32'h00000000, 32'h00000000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bclk = 1'b1;
    logic          lrclk = 1'b0;
    logic          fmt_sel = 1'b0;
    logic [LW-1:0] word_len = 6'd16;
    logic [HW-1:0] half_len = 7'd16;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [SW-1:0] in_left = '0;
    logic [SW-1:0] in_right = '0;
    logic          sdout;

    int checks = 0;
    int errors = 0;
    logic [63:0] cap;
    logic        stable_ok;
    logic [SW-1:0] last_l, last_r;

    jsa_tx u_jsa_tx (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk),
        .fmt_sel(fmt_sel), .word_len(word_len), .half_len(half_len),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .sdout(sdout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] expect_slots(input logic f, input int wl, input int hl,
                                                 input logic [SW-1:0] w);
        logic [63:0] e = '0;
        for (int k = 0; k < hl; k++) begin
            if (!f) begin
                if (k < wl) e[k] = w[wl-1-k];
            end else begin
                if (hl-1-k < wl) e[k] = w[hl-1-k];
            end
        end
        return e;
    endfunction

    task automatic half_frame(input logic lr, input int n);
        cap = '0;
        stable_ok = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bclk = 1'b0;
            if (k == 0) lrclk = lr;
            repeat (BH) @(negedge clk);
            bclk = 1'b1;
            repeat (BH/2) @(negedge clk);
            cap[k] = sdout;
            repeat (BH/2) @(negedge clk);
            if (sdout !== cap[k]) stable_ok = 1'b0;
        end
    endtask

    task automatic push(input logic [SW-1:0] l, input logic [SW-1:0] r);
        @(negedge clk);
        in_valid = 1'b1;
        in_left  = l;
        in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic frame_check(input string tag);
        half_frame(1'b1, int'(half_len));
        check({tag, " left"}, cap, expect_slots(fmt_sel, int'(word_len), int'(half_len), last_l));
        check("R1 stable left", {63'd0, stable_ok}, 64'd1);
        half_frame(1'b0, int'(half_len));
        check({tag, " right"}, cap, expect_slots(fmt_sel, int'(word_len), int'(half_len), last_r));
        check("R1 stable right", {63'd0, stable_ok}, 64'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 sdout", {63'd0, sdout}, 64'd0);
        check("R10 in_ready", {63'd0, in_ready}, 64'd1);

        for (int i = 0; i < NV; i++) begin
            string tag;
            fmt_sel  = VECS[i].fmt;
            word_len = VECS[i].wl;
            half_len = VECS[i].hl;
            if (VECS[i].load) begin
                last_l = VECS[i].l;
                last_r = VECS[i].r;
                push(VECS[i].l, VECS[i].r);
            end
            if (!VECS[i].load)            tag = "R7 repeat";
            else if (VECS[i].hl < VECS[i].wl) tag = VECS[i].fmt ? "R9" : "R8";
            else tag = VECS[i].fmt ? "R4 R5" : "R2 R3 R5";
            frame_check(tag);
        end

        // R6: held pair blocks further loads; R7: release at left start
        fmt_sel  = 1'b0;
        word_len = 6'd16;
        half_len = 7'd16;
        last_l = 32'h00001357;
        last_r = 32'h00002468;
        push(last_l, last_r);
        check("R6 ready low after accept", {63'd0, in_ready}, 64'd0);
        push(32'h0000FFFF, 32'h0000AAAA);
        check("R6 ready still low", {63'd0, in_ready}, 64'd0);
        frame_check("R6 ignored push");
        check("R7 ready after left start", {63'd0, in_ready}, 64'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule